// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

This block is a local countdown timer for a processor-side interrupt controller. Software programs a timer entry with a vector, a mask flag and a periodic flag. It also programs a divide configuration that selects a power-of-two prescale of the input clock. Writing an initial count starts the countdown. The current count can be read back at any time.

When the count passes zero, the timer raises a one-cycle interrupt request carrying the entry's vector, unless the entry is masked. In one-shot mode the count then stays at zero. In periodic mode the count reloads from the initial value and continues. Routing the request into a priority core is left to the surrounding logic.

Top module: `divcnt_timer`

## Requirements
- R1: After reset every register index (0 entry, 1 initial count, 2 current count, 3 divide configuration) reads zero and `irq_o` is low.
- R2: A write to index 3 keeps only bits 0, 1 and 3; reading index 3 returns the stored value, so writing all ones reads back 0xB.
- R3: The divide code is {cfg[3], cfg[1], cfg[0]}, the prescale shift is (code+1) mod 8, and the count advances once every 2^shift clocks; code 7 gives one tick per clock.
- R4: Writing index 1 with N loads the current count with N, readable on the cycle after the write, and clears the prescaler so that the first tick comes 2^shift clocks after the write; a rewrite while counting restarts the countdown.
- R5: In one-shot mode (entry bit 17 clear) the current count falls by one per tick. Expiry is the tick taken while the count is zero, N+1 ticks after the load. The count then holds at zero and does not expire again.
- R6: In periodic mode (entry bit 17 set) the expiring tick reloads the count with the initial value, so expiries repeat every (N+1)·2^shift clocks.
- R7: On expiry `irq_o` is high for exactly one cycle, the cycle after the expiring tick, and `irq_vector_o` equals entry bits 7:0.
- R8: With entry bit 16 set no request is raised, while the count keeps running and reloading.
- R9: Writes to index 2 are ignored; they leave the count and all other registers unchanged.
- R10: An initial count of zero stops the timer: the count reads zero and no expiry follows.
- R11: Index 0 stores and returns only bits 17, 16 and 7:0; writing all ones reads back 0x0003_00FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | One-cycle interrupt request on expiry |
| irq_vector_o | output | 8 | Vector that goes with `irq_o` |

## Verification
The bench builds the block with its default 32-bit count and 32-bit data width. Because it measures expiry with small initial counts of 1 to 5, every prescale setting up to divide-by-128 stays within a few hundred cycles. Timing can therefore be checked exactly against (N+1)·2^shift for the wrap-around code 7 as well as for the largest shift. Short counts also allow several periodic reloads and a masked reload to be observed cycle by cycle.

// File: rtl/divcnt_pkg.sv
package divcnt_pkg;
  typedef enum logic [1:0] {
    REG_ENTRY = 2'd0,
    REG_INIT  = 2'd1,
    REG_CUR   = 2'd2,
    REG_DIV   = 2'd3
  } reg_idx_e;

  localparam int VEC_W        = 8;
  localparam int SHIFT_W      = 3;
  localparam int CFG_W        = 4;
  localparam int MASK_BIT     = 16;
  localparam int PERIODIC_BIT = 17;
  localparam logic [CFG_W-1:0] CFG_KEEP = 4'b1011;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } entry_t;
endpackage

// File: rtl/divcnt_cfg_decode.sv
module divcnt_cfg_decode
  import divcnt_pkg::*;
(
  input  logic [CFG_W-1:0]   cfg_i,
  output logic [SHIFT_W-1:0] shift_o
);
  logic [SHIFT_W-1:0] code;

  // bit 3 lands in code bit 2; bit 2 of the config is not used
  assign code    = {cfg_i[3], cfg_i[1:0]};
  assign shift_o = code + SHIFT_W'(1);
endmodule

// File: rtl/divcnt_prescaler.sv
module divcnt_prescaler #(
  parameter int SHIFT_W = 3,
  localparam int PRE_W  = (1 << SHIFT_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  logic [PRE_W-1:0] presc_q;
  logic [PRE_W-1:0] low_mask;

  always_comb begin
    low_mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      low_mask[i] = (i < int'(shift_i));
    end
  end

  assign tick_o = &(presc_q | ~low_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    presc_q <= '0;
    else if (clr_i) presc_q <= '0;
    else            presc_q <= presc_q + PRE_W'(1);
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !clr_i && shift_i != '0) |=> (!tick_o || shift_i != $past(shift_i)));

  // R4
  clear_delays_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && shift_i != '0) |=> !tick_o);
endmodule

// File: rtl/divcnt_core.sv
module divcnt_core
  import divcnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             tick_i,
  input  entry_t           entry_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic [VEC_W-1:0] vec_q;
  logic             expire;

  // expiry is the tick taken while already at zero
  assign expire = tick_i && run_q && (cnt_q == '0) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      run_q <= |load_val_i;
      cnt_q <= load_val_i;
    end else if (tick_i && run_q) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end else if (entry_i.periodic) begin
        cnt_q <= init_i;
      end else begin
        run_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= expire && !entry_i.masked;
      if (expire) vec_q <= entry_i.vector;
    end
  end

  assign cnt_o     = cnt_q;
  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;

  // R10
  zero_load_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i == '0) |=> (!run_q && cnt_q == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !load_i) |=> (cnt_q == $past(cnt_q)));

  // R6
  periodic_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_q && cnt_q == '0 && entry_i.periodic && !load_i) |=> (cnt_q == $past(init_i)));

  // R7
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R8
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_i.masked |=> !irq_o);
endmodule

// File: rtl/divcnt_timer.sv
module divcnt_timer
  import divcnt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vector_o
);
  reg_idx_e           idx;
  entry_t             entry_q;
  logic [CNT_W-1:0]   init_q;
  logic [CFG_W-1:0]   div_q;
  logic [SHIFT_W-1:0] shift;
  logic               tick;
  logic               load;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  entry_rd;

  assign idx  = reg_idx_e'(reg_addr_i);
  assign load = reg_we_i && (idx == REG_INIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= '0;
      init_q  <= '0;
      div_q   <= '0;
    end else if (reg_we_i) begin
      unique case (idx)
        REG_ENTRY: begin
          entry_q.periodic <= reg_wdata_i[PERIODIC_BIT];
          entry_q.masked   <= reg_wdata_i[MASK_BIT];
          entry_q.vector   <= reg_wdata_i[VEC_W-1:0];
        end
        REG_INIT: init_q <= reg_wdata_i[CNT_W-1:0];
        REG_DIV:  div_q  <= reg_wdata_i[CFG_W-1:0] & CFG_KEEP;
        default: ;
      endcase
    end
  end

  divcnt_cfg_decode u_dec (
    .cfg_i   (div_q),
    .shift_o (shift)
  );

  divcnt_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (load),
    .shift_i (shift),
    .tick_o  (tick)
  );

  divcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (reg_wdata_i[CNT_W-1:0]),
    .init_i     (init_q),
    .tick_i     (tick),
    .entry_i    (entry_q),
    .cnt_o      (cnt),
    .irq_o      (irq_o),
    .irq_vec_o  (irq_vector_o)
  );

  always_comb begin
    entry_rd               = '0;
    entry_rd[PERIODIC_BIT] = entry_q.periodic;
    entry_rd[MASK_BIT]     = entry_q.masked;
    entry_rd[VEC_W-1:0]    = entry_q.vector;
  end

  always_comb begin
    unique case (idx)
      REG_ENTRY: reg_rdata_o = entry_rd;
      REG_INIT:  reg_rdata_o = DATA_W'(init_q);
      REG_CUR:   reg_rdata_o = DATA_W'(cnt);
      default:   reg_rdata_o = DATA_W'(div_q);
    endcase
  end

  // R9
  cur_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && idx == REG_CUR) |=> ($stable(init_q) && $stable(div_q) && $stable(entry_q)));

  // R2
  div_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && idx == REG_DIV) |=> (div_q[2] == 1'b0 && div_q[1:0] == $past(reg_wdata_i[1:0])));
endmodule

// File: tb/sim_divcnt_timer.sv
module sim_divcnt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [7:0]  vec;
  int n_chk = 0;
  int n_fail = 0;

  localparam logic [1:0] A_ENT = 2'd0, A_INI = 2'd1, A_CUR = 2'd2, A_DIV = 2'd3;

  always #10 clk = ~clk;

  divcnt_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .irq_vector_o(vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wait_irq(input int maxc, output int c);
    bit seen = 0;
    c = -1;
    for (int i = 1; i <= maxc; i++) begin
      if (!seen) begin
        step();
        if (irq) begin c = i; seen = 1; end
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset register", d, 32'h0);
    end
    chk("R1 reset irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(A_DIV, 32'hFFFF_FFFF);
    rd(A_DIV, d);
    chk("R2 divide keeps bits 0,1,3", d, 32'hB);
    wr(A_ENT, 32'hFFFF_FFFF);
    rd(A_ENT, d);
    chk("R11 entry readback", d, 32'h0003_00FF);
    wr(A_ENT, 32'h0);
  endtask

  task automatic t_divide();
    logic [3:0] cfgs [5] = '{4'hB, 4'h0, 4'h3, 4'h8, 4'hA};
    int c;
    wr(A_ENT, 32'h0);
    foreach (cfgs[k]) begin
      int code, dv;
      code = {cfgs[k][3], cfgs[k][1:0]};
      dv = 1 << ((code + 1) % 8);
      wr(A_DIV, {28'd0, cfgs[k]});
      wr(A_INI, 32'd2);
      wait_irq(400, c);
      chk("R3 expiry after 3 ticks at divisor", c, 3 * dv);
    end
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(A_ENT, 32'h42);
    wr(A_DIV, 32'hB);
    wr(A_INI, 32'd5);
    addr = A_CUR; #1;
    chk("R4 count loaded", rdata, 32'd5);
    for (int i = 1; i <= 5; i++) begin
      step();
      chk("R5 one-shot decrement", rdata, 32'(5 - i));
      chk("R5 no early irq", {31'd0, irq}, 32'h0);
    end
    step();
    chk("R7 irq on expiry", {31'd0, irq}, 32'h1);
    chk("R7 vector", {24'd0, vec}, 32'h42);
    chk("R5 count at zero", rdata, 32'h0);
    step();
    chk("R7 single-cycle pulse", {31'd0, irq}, 32'h0);
    for (int i = 0; i < 10; i++) begin
      step();
      if (irq || rdata != 0) chk("R5 hold at zero", {31'd0, irq} | rdata, 32'h0);
    end
    rd(A_CUR, d);
    chk("R5 still zero", d, 32'h0);
  endtask

  task automatic t_periodic();
    int c;
    wr(A_ENT, (32'h1 << 17) | 32'h21);
    wr(A_DIV, 32'h0);
    wr(A_INI, 32'd3);
    addr = A_CUR;
    for (int p = 0; p < 3; p++) begin
      wait_irq(40, c);
      chk("R6 period (N+1)*D", c, 8);
      chk("R6 reload value", rdata, 32'd3);
      chk("R7 periodic vector", {24'd0, vec}, 32'h21);
    end
    wr(A_INI, 32'd0);
  endtask

  task automatic t_masked();
    int hits = 0;
    wr(A_ENT, (32'h3 << 16) | 32'h10);
    wr(A_DIV, 32'hB);
    wr(A_INI, 32'd2);
    addr = A_CUR;
    for (int i = 1; i <= 12; i++) begin
      step();
      if (irq) hits++;
      if (i == 3) chk("R8 masked count still reloads", rdata, 32'd2);
    end
    chk("R8 masked no irq", hits, 0);
    wr(A_INI, 32'd0);
  endtask

  task automatic t_cur_write();
    logic [31:0] d;
    wr(A_ENT, 32'h0);
    wr(A_DIV, 32'hB);
    wr(A_INI, 32'd100);
    wr(A_CUR, 32'd7);
    rd(A_CUR, d);
    chk("R9 current count unaffected", d, 32'd99);
    rd(A_INI, d);
    chk("R9 initial unaffected", d, 32'd100);
    rd(A_DIV, d);
    chk("R9 divide unaffected", d, 32'hB);
    wr(A_INI, 32'd0);
  endtask

  task automatic t_zero();
    int c;
    logic [31:0] d;
    wr(A_ENT, 32'h0);
    wr(A_INI, 32'd50);
    step();
    wr(A_INI, 32'd0);
    rd(A_CUR, d);
    chk("R10 zero count reads zero", d, 32'h0);
    wait_irq(60, c);
    chk("R10 no expiry", c, -1);
  endtask

  task automatic t_restart();
    int c;
    wr(A_ENT, 32'h0);
    wr(A_DIV, 32'hB);
    wr(A_INI, 32'd4);
    step(); step();
    wr(A_INI, 32'd4);
    addr = A_CUR; #1;
    chk("R4 rewrite reloads count", rdata, 32'd4);
    wait_irq(20, c);
    chk("R4 restart timing", c, 5);
    wr(A_DIV, 32'h1);
    wr(A_INI, 32'd1);
    step(); step(); step();
    wr(A_INI, 32'd1);
    wait_irq(40, c);
    chk("R4 prescaler cleared on load", c, 8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_divide();
    t_oneshot();
    t_periodic();
    t_masked();
    t_cur_write();
    t_zero();
    t_restart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule